// File: doc/BRIEF.md
# Deferred Counter Increment Scheduler

This block holds a small pool of additions that are waiting to happen. A client offers one request per cycle through a valid/ready handshake. Each request carries a register index, a signed amount and a delay in cycles. On acceptance the block stamps the request with an absolute due time, which is the value of its free-running 32-bit cycle counter plus the delay.

Every cycle, each held entry whose due time has been reached is folded into a bank of accumulator registers, and its slot is freed. Any number of entries can fall due in the same cycle. Entries that target the same register in that cycle have their amounts summed. A combinational read port exposes any register, and an output reports how many entries are still waiting.

Due times are compared with a wrap-safe signed difference, so counter roll-over does not disturb the ordering.

Top module: `deferred_add_sched`

## Requirements
- R1: After reset all eight registers read 0, `pending_count` is 0 and `post_ready` is 1.
- R2: A request is accepted on a rising edge where `post_valid` and `post_ready` are both 1. After that edge `pending_count` is one higher, unless entries were released on the same edge.
- R3: A request accepted on edge E with delay d of 1 or more changes its register on edge E+d. With delay 0 it changes its register on edge E+1. The register holds its old value before that edge.
- R4: The 8-bit amount is two's complement and is sign-extended to the 16-bit register width. Register arithmetic wraps modulo 2^16.
- R5: All entries due on the same edge are applied on that edge. Amounts that target the same register are summed into it.
- R6: An applied entry frees its slot. `pending_count` drops by the number of entries released on that edge.
- R7: The pool has 8 slots. `post_ready` is 0 exactly when all 8 are occupied. A request offered while `post_ready` is 0 is dropped: no register changes and `pending_count` is unaffected by it.
- R8: A held entry with a long delay leaves every register unchanged until its due edge, even while other entries are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| post_valid | input | 1 | Request offered this cycle |
| post_ready | output | 1 | A free slot exists; the request is taken on this edge |
| post_target | input | 3 | Index of the register to add into |
| post_amount | input | 8 | Signed amount to add |
| post_delay | input | 16 | Cycles from acceptance until the add is applied |
| rd_index | input | 3 | Register index to read |
| rd_data | output | 16 | Current value of the selected register |
| pending_count | output | 4 | Number of entries waiting |

## Verification
The bench goes after three timing points: a delay of zero, a delay of one, and long delays. A design that compared with the wrong inequality would apply the add one edge early or one edge late, and the bench compares every register on every cycle.

Four entries staggered to fall due on the same edge, three of them aimed at one register, catch a design that applies only one entry per cycle or lets one add overwrite another.

Negative amounts that cross zero expose a missing sign extension. A request offered into a full pool exposes a design that overwrites a live slot or counts a refused request. The pending count is compared every cycle, which catches a release that forgets to decrement it, or decrements it once when several entries leave together.

// File: rtl/sched_pkg.sv
package sched_pkg;

    localparam int NREG      = 8;
    localparam int TGT_W     = $clog2(NREG);
    localparam int AMT_W     = 8;
    localparam int DLY_W     = 16;
    localparam int CNT_W     = 32;
    localparam int BANK_W    = 16;
    localparam int DEF_SLOTS = 8;

    typedef logic [CNT_W-1:0] tick_t;

    typedef struct packed {
        logic [TGT_W-1:0]        tgt;
        logic signed [AMT_W-1:0] amt;
        tick_t                   due;
    } pend_t;

    // True once the counter has reached or passed the due stamp (wrap-safe).
    function automatic logic reached(tick_t now, tick_t due);
        tick_t diff;
        diff = now - due;
        return !diff[CNT_W-1];
    endfunction

    function automatic pend_t make_entry(logic [TGT_W-1:0] tgt,
                                         logic signed [AMT_W-1:0] amt,
                                         logic [DLY_W-1:0] dly,
                                         tick_t now);
        pend_t e;
        e.tgt = tgt;
        e.amt = amt;
        e.due = now + tick_t'(dly);
        return e;
    endfunction

endpackage

// File: rtl/sched_cycle_timer.sv
module sched_cycle_timer
    import sched_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    output tick_t now
);

    tick_t cnt_q;

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_q + tick_t'(1);
    end

    assign now = cnt_q;

endmodule

// File: rtl/sched_slot_queue.sv
module sched_slot_queue
    import sched_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    localparam int CW = $clog2(NUM_SLOTS + 1),
    localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  tick_t                 now,
    input  logic                  push_en,
    input  pend_t                 push_ent,
    output logic                  full,
    output logic [NUM_SLOTS-1:0]  due_vec,
    output pend_t [NUM_SLOTS-1:0] slots,
    output logic [CW-1:0]         count
);

    logic [NUM_SLOTS-1:0]  valid_q;
    pend_t [NUM_SLOTS-1:0] slot_q;
    logic [CW-1:0]         count_q;
    logic                  free_hit;
    logic [IW-1:0]         free_idx;
    logic [CW-1:0]         release_n;
    logic                  take;

    // Lowest-index free slot.
    always_comb begin
        free_hit = 1'b0;
        free_idx = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (!valid_q[i] && !free_hit) begin
                free_hit = 1'b1;
                free_idx = IW'(i);
            end
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_due
        assign due_vec[g] = valid_q[g] && reached(now, slot_q[g].due);
    end

    always_comb begin
        release_n = '0;
        for (int i = 0; i < NUM_SLOTS; i++)
            release_n = release_n + CW'(due_vec[i]);
    end

    assign take = push_en && free_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            count_q <= '0;
        end else begin
            for (int i = 0; i < NUM_SLOTS; i++)
                if (due_vec[i]) valid_q[i] <= 1'b0;
            if (take) begin
                valid_q[free_idx] <= 1'b1;
                slot_q[free_idx]  <= push_ent;
            end
            count_q <= count_q + CW'(take) - release_n;
        end
    end

    assign full  = &valid_q;
    assign slots = slot_q;
    assign count = count_q;

    a_r6_count_tracks: assert property (@(posedge clk) disable iff (rst)
        32'(count_q) == $countones(valid_q));

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_chk
        a_r6_slot_freed: assert property (@(posedge clk) disable iff (rst)
            due_vec[g] |=> !valid_q[g]);
        a_r3_not_late: assert property (@(posedge clk) disable iff (rst)
            valid_q[g] |-> ($signed(now - slot_q[g].due) <= 1));
    end

endmodule

// File: rtl/sched_add_combiner.sv
module sched_add_combiner
    import sched_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int REG_W     = BANK_W
) (
    input  logic [NUM_SLOTS-1:0]       due_vec,
    input  pend_t [NUM_SLOTS-1:0]      slots,
    output logic [NREG-1:0][REG_W-1:0] delta
);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_comb begin
            delta[r] = '0;
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (due_vec[i] && slots[i].tgt == TGT_W'(r))
                    delta[r] = delta[r] +
                        {{(REG_W-AMT_W){slots[i].amt[AMT_W-1]}}, slots[i].amt};
            end
        end
    end

endmodule

// File: rtl/sched_reg_bank.sv
module sched_reg_bank
    import sched_pkg::*;
#(
    parameter int REG_W = BANK_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NREG-1:0][REG_W-1:0] delta,
    input  logic [TGT_W-1:0]           rd_index,
    output logic [REG_W-1:0]           rd_data
);

    logic [NREG-1:0][REG_W-1:0] regs_q;

    for (genvar r = 0; r < NREG; r++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst) regs_q[r] <= '0;
            else     regs_q[r] <= regs_q[r] + delta[r];
        end
    end

    assign rd_data = regs_q[rd_index];

endmodule

// File: rtl/deferred_add_sched.sv
module deferred_add_sched
    import sched_pkg::*;
#(
    parameter int NUM_SLOTS = DEF_SLOTS,
    parameter int REG_W     = BANK_W,
    localparam int CW = $clog2(NUM_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              post_valid,
    output logic              post_ready,
    input  logic [TGT_W-1:0]  post_target,
    input  logic [AMT_W-1:0]  post_amount,
    input  logic [DLY_W-1:0]  post_delay,
    input  logic [TGT_W-1:0]  rd_index,
    output logic [REG_W-1:0]  rd_data,
    output logic [CW-1:0]     pending_count
);

    tick_t                      now;
    logic                       full;
    logic [NUM_SLOTS-1:0]       due_vec;
    pend_t [NUM_SLOTS-1:0]      slots;
    logic [NREG-1:0][REG_W-1:0] delta;
    pend_t                      new_ent;
    logic                       push_en;

    assign post_ready = !full;
    assign push_en    = post_valid && post_ready;
    assign new_ent    = make_entry(post_target, post_amount, post_delay, now);

    sched_cycle_timer u_timer (
        .clk (clk),
        .rst (rst),
        .now (now)
    );

    sched_slot_queue #(.NUM_SLOTS(NUM_SLOTS)) u_queue (
        .clk      (clk),
        .rst      (rst),
        .now      (now),
        .push_en  (push_en),
        .push_ent (new_ent),
        .full     (full),
        .due_vec  (due_vec),
        .slots    (slots),
        .count    (pending_count)
    );

    sched_add_combiner #(.NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W)) u_comb (
        .due_vec (due_vec),
        .slots   (slots),
        .delta   (delta)
    );

    sched_reg_bank #(.REG_W(REG_W)) u_bank (
        .clk      (clk),
        .rst      (rst),
        .delta    (delta),
        .rd_index (rd_index),
        .rd_data  (rd_data)
    );

    a_r7_ready_matches_room: assert property (@(posedge clk) disable iff (rst)
        post_ready == (32'(pending_count) < NUM_SLOTS));

    a_r7_refused_no_growth: assert property (@(posedge clk) disable iff (rst)
        (post_valid && !post_ready) |=> (pending_count <= $past(pending_count)));

    a_r8_idle_regs_hold: assert property (@(posedge clk) disable iff (rst)
        (pending_count == '0) |=>
            (rd_index != $past(rd_index) || rd_data == $past(rd_data)));

endmodule

// File: tb/deferred_add_sched_tb.sv
`timescale 1ns/1ps
module deferred_add_sched_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        post_valid = 1'b0;
    logic        post_ready;
    logic [2:0]  post_target = '0;
    logic [7:0]  post_amount = '0;
    logic [15:0] post_delay = '0;
    logic [2:0]  rd_index = '0;
    logic [15:0] rd_data;
    logic [3:0]  pending_count;

    always #4 clk = ~clk;

    deferred_add_sched dut_i (
        .clk           (clk),
        .rst           (rst),
        .post_valid    (post_valid),
        .post_ready    (post_ready),
        .post_target   (post_target),
        .post_amount   (post_amount),
        .post_delay    (post_delay),
        .rd_index      (rd_index),
        .rd_data       (rd_data),
        .pending_count (pending_count)
    );

    typedef struct {
        int tgt;
        int amt;
        int edge_no;
    } item_t;

    item_t       sb_q[$];
    logic [15:0] mreg [8];
    int          cyc = 0;
    int          checks = 0;
    int          errors = 0;
    string       phase = "R1";
    bit          mon_en = 1'b0;
    bit          done = 1'b0;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d (edge %0d)",
                     tag, what, act, exp, cyc);
        end
    endtask

    // Monitor: retire due items from the scoreboard and compare the bank.
    always begin
        @(negedge clk);
        if (!rst && mon_en) begin
            for (int i = sb_q.size() - 1; i >= 0; i--) begin
                if (sb_q[i].edge_no <= cyc) begin
                    mreg[sb_q[i].tgt] = mreg[sb_q[i].tgt] + 16'(sb_q[i].amt);
                    sb_q.delete(i);
                end
            end
            chk(phase, "pending_count", int'(pending_count), sb_q.size());
            for (int r = 0; r < 8; r++) begin
                rd_index = 3'(r);
                #0.2;
                chk(phase, $sformatf("reg%0d", r), int'(rd_data), int'(mreg[r]));
            end
        end
    end

    // Driver: offer one request for one edge; push the expectation if taken.
    task automatic post(int t, int a, int d);
        bit exp_rdy;
        int e;
        @(negedge clk);
        #2;
        exp_rdy = (sb_q.size() < 8);
        chk(phase, "post_ready", int'(post_ready), int'(exp_rdy));
        e = cyc + 1;
        post_target = 3'(t);
        post_amount = 8'(a);
        post_delay  = 16'(d);
        post_valid  = 1'b1;
        @(posedge clk);
        #1;
        post_valid = 1'b0;
        if (exp_rdy) sb_q.push_back('{t, a, e + ((d == 0) ? 1 : d)});
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    initial begin
        for (int r = 0; r < 8; r++) mreg[r] = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        #2;
        // R1: reset state
        chk("R1", "post_ready", int'(post_ready), 1);
        chk("R1", "pending_count", int'(pending_count), 0);
        mon_en = 1'b1;
        idle(2);

        // R2: single acceptance raises the count
        phase = "R2";
        post(1, 10, 6);
        idle(8);

        // R3: delay 0, delay 1 and a longer delay on distinct registers
        phase = "R3";
        post(0, 3, 0);
        post(2, 4, 1);
        post(3, 9, 5);
        idle(8);

        // R8: long wait while other entries come and go
        phase = "R8";
        post(7, 20, 30);
        post(4, 1, 2);
        post(4, 2, 3);
        idle(34);

        // R4: negative amounts, sign extension and wrap
        phase = "R4";
        post(6, -1, 1);
        post(6, 2, 1);
        post(5, -128, 1);
        post(5, 127, 1);
        post(6, -3, 2);
        idle(5);

        // R5: four entries due on one edge, three on register 2
        phase = "R5";
        post(2, 5, 4);
        post(2, 7, 3);
        post(5, -3, 2);
        post(2, -1, 1);
        idle(6);

        // R6: several entries released together and apart
        phase = "R6";
        post(1, 1, 3);
        post(3, 2, 2);
        post(0, 4, 4);
        idle(8);

        // R7: fill all slots, then offer a ninth request
        phase = "R7";
        for (int i = 0; i < 8; i++) post(i, 1, 40);
        post(0, 50, 1);
        chk("R7", "ninth dropped, pending", int'(pending_count), 8);
        idle(45);
        post(0, 6, 1);
        idle(4);

        done = 1'b1;
        finish_run();
    end

endmodule